// File: doc/BRIEF.md
# SCCB Register Read Master

This block reads one 8-bit register from a camera sensor over a two-wire serial camera control bus. A one-cycle pulse on `start_i` captures the register number. The block then runs two separate bus frames. The first frame is a write: a start condition, the device write address 0x42, an acknowledge slot, the register number and a second acknowledge slot, closed by a full stop. The second frame opens with a fresh start condition. It sends the device read address 0x43, waits through an acknowledge slot, shifts in the data byte and closes with a master not-acknowledge and a stop.

All logic runs on the system clock. A divider produces a one-cycle enable four times per bit, and each bit period is cut into four quarters: SDA set-up, SCL rise, SDA sample and SCL fall. SDA is open drain. The block only ever pulls the line low through `sda_oe_o` and reads the line back on `sda_i`. The 7-bit device identity is a parameter, with default 0x21. An acknowledge slot that reads high sets `ack_err_o`, but the transfer still runs through to its final stop. The result appears on `rdata_o` with a one-cycle `done_o` pulse.

Top module: `sccb_reg_reader`

## Requirements
- R1: In reset and while idle, SCL is high, SDA is released (`sda_oe_o` = 0) and `done_o` is low.
- R2: The first frame carries, MSB first, the byte 0x42 and then the captured register number. Each byte is followed by a slot in which the master releases SDA.
- R3: The bus event order for one read is: start, byte, byte, stop, start, byte, byte, stop. A repeated start never replaces the stop and start between the frames.
- R4: The second frame's first byte is 0x43, which has bit 0 = 1 for read, followed by a released acknowledge slot.
- R5: The slave's byte is sampled MSB first with SDA released, and it appears on `rdata_o` when `done_o` pulses.
- R6: After the eighth data bit, SDA is high (released) during the ninth SCL high period, and a stop condition follows.
- R7: Consecutive SCL rising edges within a byte are 4*ceil(CLK_HZ/(4*BIT_HZ)) clock cycles apart, so the bit rate never exceeds BIT_HZ.
- R8: SDA changes while SCL is high only for start and stop conditions. Exactly two falls and two rises of that kind occur per read.
- R9: If any of the three acknowledge slots samples SDA high, `ack_err_o` is 1 at `done_o`; otherwise it is 0. Either way, the full event sequence of R3 completes.
- R10: `done_o` is high for exactly one cycle per read, and `ack_err_o` clears on the cycle after an accepted start.
- R11: A start pulse during a transfer is ignored. The register byte sent stays the one captured first, and only one `done_o` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a read |
| reg_addr_i | input | 8 | Register number, captured with the start pulse |
| rdata_o | output | 8 | Byte read from the slave |
| done_o | output | 1 | One-cycle pulse when the read has finished |
| ack_err_o | output | 1 | An acknowledge slot was sampled high |
| scl_o | output | 1 | Serial clock |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sampled level of the SDA line |

## Verification
The bench builds the block with CLK_HZ = 1,500,000 and BIT_HZ = 100,000. The quarter divider then rounds 3.75 up to 4, so the 16-cycle bit period tests the rounding towards a slower bit rate. A whole two-frame read takes about 640 cycles. This allows many random register and data values, every single missing acknowledge, and a start request in the middle of a transfer within the run. A slave model on the bench answers on the open-drain line and decodes starts, stops and bytes from the pins alone.

// File: rtl/sccb_reg_reader.sv
module sccb_reg_reader #(
  parameter int CLK_HZ = 50_000_000,
  parameter int BIT_HZ = 100_000,
  parameter logic [6:0] DEV_ID = 7'h21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] reg_addr_i,
  output logic [7:0] rdata_o,
  output logic       done_o,
  output logic       ack_err_o,
  output logic       scl_o,
  output logic       sda_oe_o,
  input  logic       sda_i
);
  localparam int QDIV = (CLK_HZ + 4 * BIT_HZ - 1) / (4 * BIT_HZ);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [5:0] SL_START1 = 6'd0;
  localparam logic [5:0] SL_ACK1   = 6'd9;
  localparam logic [5:0] SL_ACK2   = 6'd18;
  localparam logic [5:0] SL_STOP1  = 6'd19;
  localparam logic [5:0] SL_START2 = 6'd20;
  localparam logic [5:0] SL_ACK3   = 6'd29;
  localparam logic [5:0] SL_RD0    = 6'd30;
  localparam logic [5:0] SL_RD7    = 6'd37;
  localparam logic [5:0] SL_STOP2  = 6'd39;

  logic          busy;
  logic [5:0]    slot;
  logic [1:0]    q;
  logic [CW-1:0] cnt;
  logic [7:0]    reg_q;
  logic [7:0]    shr;
  logic          tick;
  logic          tx_on;
  logic [7:0]    tx_byte;
  logic [2:0]    bidx;
  logic          is_ack;
  logic          is_rd;

  assign tick   = busy && (cnt == CW'(QDIV - 1));
  assign is_ack = (slot == SL_ACK1) || (slot == SL_ACK2) || (slot == SL_ACK3);
  assign is_rd  = (slot >= SL_RD0) && (slot <= SL_RD7);

  always_comb begin
    tx_on   = 1'b0;
    tx_byte = 8'h00;
    bidx    = 3'd0;
    if (slot >= 6'd1 && slot <= 6'd8) begin
      tx_on = 1'b1; tx_byte = {DEV_ID, 1'b0}; bidx = 3'(6'd8 - slot);
    end else if (slot >= 6'd10 && slot <= 6'd17) begin
      tx_on = 1'b1; tx_byte = reg_q; bidx = 3'(6'd17 - slot);
    end else if (slot >= 6'd21 && slot <= 6'd28) begin
      tx_on = 1'b1; tx_byte = {DEV_ID, 1'b1}; bidx = 3'(6'd28 - slot);
    end
  end

  always_comb begin
    scl_o    = 1'b1;
    sda_oe_o = 1'b0;
    if (busy) begin
      if (slot == SL_START1 || slot == SL_START2) begin
        scl_o    = (q != 2'd3);
        sda_oe_o = (q != 2'd0);
      end else if (slot == SL_STOP1 || slot == SL_STOP2) begin
        scl_o    = (q != 2'd0);
        sda_oe_o = (q < 2'd2);
      end else begin
        scl_o    = (q == 2'd1) || (q == 2'd2);
        sda_oe_o = tx_on && !tx_byte[bidx];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      slot      <= 6'd0;
      q         <= 2'd0;
      cnt       <= '0;
      reg_q     <= 8'h00;
      shr       <= 8'h00;
      rdata_o   <= 8'h00;
      done_o    <= 1'b0;
      ack_err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy) begin
        busy      <= 1'b1;
        slot      <= SL_START1;
        q         <= 2'd0;
        cnt       <= '0;
        reg_q     <= reg_addr_i;
        ack_err_o <= 1'b0;
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) begin
          q <= q + 2'd1;
          if (q == 2'd2) begin
            if (is_ack && sda_i) ack_err_o <= 1'b1;
            if (is_rd) shr <= {shr[6:0], sda_i};
          end
          if (q == 2'd3) begin
            if (slot == SL_STOP2) begin
              busy    <= 1'b0;
              done_o  <= 1'b1;
              rdata_o <= shr;
            end else begin
              slot <= slot + 6'd1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sccb_reg_reader_chk.sv
module sccb_reg_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       done_o,
  input logic       scl_o,
  input logic       sda_oe_o,
  input logic       busy,
  input logic [5:0] slot,
  input logic [7:0] reg_q
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_o && !sda_oe_o)); // R1
  AST_ACK_SLOT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (slot == 6'd9 || slot == 6'd18)) |-> !sda_oe_o); // R2
  AST_READ_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot == 6'd29) |-> !sda_oe_o); // R4
  AST_DATA_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot >= 6'd30 && slot <= 6'd38) |-> !sda_oe_o); // R6
  AST_SDA_EDGE_ONLY_START_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_o) && scl_o && (sda_oe_o != $past(sda_oe_o)))
      |-> (slot == 6'd0 || slot == 6'd19 || slot == 6'd20 || slot == 6'd39)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_o); // R10
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && slot != 6'd39) |=> (busy && $stable(reg_q))); // R11
endmodule

bind sccb_reg_reader sccb_reg_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
  .scl_o(scl_o), .sda_oe_o(sda_oe_o), .busy(busy), .slot(slot), .reg_q(reg_q)
);

// File: tb/sccb_reg_reader_test.sv
module sccb_reg_reader_test;
  localparam int CLK_HZ = 1_500_000;
  localparam int BIT_HZ = 100_000;

  function automatic int exp_period();
    return 4 * ((CLK_HZ + 4 * BIT_HZ - 1) / (4 * BIT_HZ));
  endfunction
  function automatic logic [7:0] exp_tx(input int i, input logic [7:0] ra);
    return (i == 0) ? 8'h42 : (i == 1) ? ra : 8'h43;
  endfunction
  function automatic logic exp_err(input logic [2:0] give);
    return give != 3'b111;
  endfunction

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [7:0] reg_addr_i = 8'h00;
  logic [7:0] rdata_o;
  logic done_o, ack_err_o, scl_o, sda_oe_o;
  logic sl_pull = 1'b0;
  wire  sda_line = !(sda_oe_o || sl_pull);

  sccb_reg_reader #(.CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .reg_addr_i(reg_addr_i),
    .rdata_o(rdata_o), .done_o(done_o), .ack_err_o(ack_err_o),
    .scl_o(scl_o), .sda_oe_o(sda_oe_o), .sda_i(sda_line));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  int cyc = 0, last_rise = 0, bitcnt = 0, fb = 0, nb = 0, ai = 0, nev = 0, rdix = 0;
  int hi_changes = 0, per_bad = 0;
  bit rd_frame = 0, nack_ok = 0, p_scl = 1, p_sda = 1;
  logic [7:0] shreg = 8'h00, sl_data = 8'h00;
  logic [7:0] bytes [4];
  int ev [12];
  logic [2:0] ack_give = 3'b111;

  task automatic ev_push(input int code);
    if (nev < 12) ev[nev] = code;
    nev++;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      p_scl = 1; p_sda = 1;
    end else begin
      if (p_scl && scl_o) begin
        if (p_sda && !sda_line) begin
          ev_push(1); hi_changes++; bitcnt = 0; fb = 0; rd_frame = 0; sl_pull = 0;
        end else if (!p_sda && sda_line) begin
          ev_push(2); hi_changes++; sl_pull = 0;
        end
      end
      if (!p_scl && scl_o) begin
        if (bitcnt < 8) begin
          if (bitcnt > 0 && cyc - last_rise != exp_period()) per_bad++;
          last_rise = cyc;
          shreg = {shreg[6:0], sda_line};
          bitcnt++;
        end else if (bitcnt == 9 && rd_frame && fb == 2) begin
          nack_ok = sda_line;
        end
      end
      if (p_scl && !scl_o) begin
        if (bitcnt == 8) begin
          ev_push(3);
          if (fb == 0) rd_frame = shreg[0];
          if (rd_frame && fb == 1) sl_pull = 0;
          else begin
            if (nb < 4) bytes[nb] = shreg;
            nb++;
            sl_pull = (ai < 3) ? ack_give[ai] : 1'b0;
            ai++;
          end
          fb++; bitcnt = 9;
        end else if (bitcnt == 9) begin
          bitcnt = 0;
          if (rd_frame && fb == 1) begin sl_pull = !sl_data[7]; rdix = 6; end
          else sl_pull = 0;
        end else if (rd_frame && fb == 1 && bitcnt > 0 && rdix >= 0) begin
          sl_pull = !sl_data[rdix]; rdix--;
        end
      end
      p_scl = scl_o; p_sda = sda_line;
    end
  end

  task automatic run(input logic [7:0] ra, input logic [7:0] dv, input logic [2:0] give, input bit poke);
    int dcount = 0;
    bit seen = 0;
    logic [7:0] got = 8'h00;
    logic err = 1'b0;
    int exp_ev [8] = '{1, 3, 3, 2, 1, 3, 3, 2};
    bit ev_ok;
    nev = 0; nb = 0; ai = 0; hi_changes = 0; per_bad = 0; nack_ok = 0;
    sl_data = dv; ack_give = give; bitcnt = 0; fb = 0; rd_frame = 0;
    @(negedge clk); start_i = 1'b1; reg_addr_i = ra;
    @(negedge clk); start_i = 1'b0; reg_addr_i = 8'h00;
    chk(ack_err_o == 1'b0, "R10 ack_err cleared after start", ack_err_o, 0);
    for (int n = 0; n < 1200; n++) begin
      @(negedge clk);
      if (poke && n == 300) begin start_i = 1'b1; reg_addr_i = ~ra; end
      if (poke && n == 301) begin start_i = 1'b0; reg_addr_i = 8'h00; end
      if (done_o) begin
        dcount++;
        if (!seen) begin got = rdata_o; err = ack_err_o; end
        seen = 1;
      end
    end
    chk(nb == 3, "R2 address byte count", nb, 3);
    chk(bytes[0] == exp_tx(0, ra), "R2 device write address", bytes[0], exp_tx(0, ra));
    chk(bytes[1] == exp_tx(1, ra), "R2 R11 register byte", bytes[1], exp_tx(1, ra));
    chk(bytes[2] == exp_tx(2, ra), "R4 device read address", bytes[2], exp_tx(2, ra));
    ev_ok = (nev == 8);
    for (int i = 0; i < 8; i++) if (ev_ok && ev[i] != exp_ev[i]) ev_ok = 0;
    chk(ev_ok, "R3 R9 bus event order", nev, 8);
    chk(got == dv, "R5 read data", got, dv);
    chk(nack_ok, "R6 master not-acknowledge", nack_ok, 1);
    chk(per_bad == 0, "R7 bit period", per_bad, 0);
    chk(hi_changes == 4, "R8 SDA changes while SCL high", hi_changes, 4);
    chk(err == exp_err(give), "R9 ack error flag", err, exp_err(give));
    chk(dcount == 1, "R10 R11 done pulse count", dcount, 1);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(scl_o && !sda_oe_o && !done_o, "R1 reset bus idle", {scl_o, sda_oe_o, done_o}, 3'b100);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(scl_o && !sda_oe_o && !done_o, "R1 idle after reset", {scl_o, sda_oe_o, done_o}, 3'b100);
    run(8'h00, 8'hFF, 3'b111, 0);
    run(8'hFF, 8'h00, 3'b111, 0);
    run(8'h1C, 8'h7F, 3'b111, 0);
    run(8'h0A, 8'h5A, 3'b110, 0);
    run(8'h0B, 8'hA5, 3'b101, 0);
    run(8'h0C, 8'h81, 3'b011, 0);
    run(8'h0D, 8'h3C, 3'b111, 0);
    run(8'h55, 8'hC3, 3'b111, 1);
    for (int k = 0; k < 10; k++) begin
      logic [7:0] ra, dv;
      logic [2:0] g;
      ra = 8'($urandom);
      dv = 8'($urandom);
      g = ($urandom % 4 == 0) ? 3'($urandom) : 3'b111;
      run(ra, dv, g, ($urandom % 5) == 0);
    end
    repeat (5) @(negedge clk);
    chk(scl_o && !sda_oe_o && !done_o, "R1 idle at end", {scl_o, sda_oe_o, done_o}, 3'b100);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule